// File: doc/BRIEF.md
# Reset Sequencer with Configuration Strap Capture

This block turns a raw, active-low board reset pin into a clean internal reset for a timing device running from a 12.8 MHz master clock. A low level on the pin only counts once it has lasted a full qualification window of `QUAL_CYCLES` cycles. The default is 640 cycles, which is 50 µs. After the pin goes high again, the internal reset is held for a further `HOLD_CYCLES` cycles. The default is 6,400,000 cycles, which is 500 ms. A qualified low seen at any time, including during that hold, starts the sequence again. A low pulse shorter than the window changes nothing.

While the internal reset is active, two configuration pins are sampled on every cycle. The fast-selection pin sets the default of the fast-selection enable bit. The line-standard pin sets the default of the SONET/SDH mode bit. The values kept are those seen on the last cycle before release. After release, the line-standard pin is ignored. The fast-selection pin is used again as a live choice between two reference input pairs, but only while the enable bit is set. A small write port lets software replace either captured bit once the device is out of reset. The master/slave pin is passed through as a live level at all times. Every pin passes through a two-flop synchronizer before it is used.

Top module: `strap_reset_seq`

## Requirements
- R1: While `powerOnRstN` is low, and on its release, `sysRstN`, `fastSelEn`, `sonetMode`, `pairSelA` and `masterLive` are all 0.
- R2: Every pin input is synchronized by two flops, so `masterLive` shows the `masterPin` level sampled two rising edges earlier.
- R3: When `QUAL_CYCLES` consecutive synchronized low samples of `rstPinN` are seen, `sysRstN` is 0 after that edge. A low run of `QUAL_CYCLES`-1 samples or fewer leaves `sysRstN` unchanged.
- R4: Once the synchronized reset pin is seen high, `sysRstN` stays 0 for `HOLD_CYCLES` more edges and then goes to 1. A low pulse shorter than the window during the hold does not change the hold length.
- R5: A qualified low during the hold keeps `sysRstN` at 0 and restarts the hold count from the next release.
- R6: `fastSelEn` and `sonetMode` take the synchronized `fastSelPin` and `sonetSdhPin` levels of the last cycle with reset active (1 = enabled / SONET, 0 = disabled / SDH). After release, the pins do not change them.
- R7: Out of reset with `fastSelEn`=1, `pairSelA` takes the synchronized `fastSelPin` one edge later (1 selects pair A, inputs 3 and 5; 0 selects pair B, inputs 4 and 6). With `fastSelEn`=0, or in reset, `pairSelA` holds its value.
- R8: Out of reset, a write (`wrEn`=1) to address 0x0B loads `fastSelEn` from `wrData[4]`, and a write to address 0x09 loads `sonetMode` from `wrData[2]`. Writes to other addresses, and writes while reset is active, have no effect.
- R9: `masterLive` follows the pin during reset as well as after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12.8 MHz master clock |
| powerOnRstN | input | 1 | Asynchronous power-on reset of the sequencer, active low |
| rstPinN | input | 1 | Raw board reset pin, active low, asynchronous |
| fastSelPin | input | 1 | Fast-selection strap and live pair choice, asynchronous |
| sonetSdhPin | input | 1 | Line-standard strap, asynchronous |
| masterPin | input | 1 | Master/slave level, asynchronous |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | DATA_W | Register write data |
| sysRstN | output | 1 | Internal reset, active low |
| fastSelEn | output | 1 | Fast-selection enable bit |
| sonetMode | output | 1 | Line-standard bit, 1 = SONET |
| masterLive | output | 1 | Synchronized master/slave level |
| pairSelA | output | 1 | Reference pair choice, 1 = pair A |

## Verification
- **`masterLive`:** due two rising edges after a pin change.
- **`pairSelA`:** due three rising edges after a fast-selection pin change, provided the enable is set.
- **Write port:** a write changes its bit one edge after the strobe.
- **Entering reset:** `sysRstN` falls `QUAL_CYCLES`+2 edges after the raw pin goes low.
- **Leaving reset:** `sysRstN` rises `HOLD_CYCLES`+3 edges after the raw pin goes high.

The bench changes inputs only on the falling clock edge. It advances a behavioural model on each rising edge and compares every output with that model on the next falling edge, so each result is checked in the cycle it is due. Directed checks at the window boundaries (`QUAL_CYCLES`-1 and `QUAL_CYCLES` low samples, a short pulse during the hold, and a restart during the hold) are sampled on falling edges that are counted from the stimulus.

// File: rtl/strap_reset_pkg.sv
package strap_reset_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    SEQ_ARMED = 2'd0,  // qualified low seen, waiting for pin release
    SEQ_HOLD  = 2'd1,  // pin released, counting the hold time
    SEQ_RUN   = 2'd2   // internal reset released
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // reset active: sample straps into the config bits
    logic update;   // running: live pair selection and register writes
  } seqStrobe_t;

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain <= '0;
      end else begin
        chain <= {chain[STAGES-2:0], asyncIn[b]};
      end
    end

    assign syncOut[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/strap_reset_ctrl.sv
module strap_reset_ctrl
  import strap_reset_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = 640,
  parameter int unsigned HOLD_CYCLES = 6400000
) (
  input  logic       clk,
  input  logic       powerOnRstN,
  input  logic       rstSync,
  output seqStrobe_t strobe,
  output logic       sysRstN
);

  localparam int unsigned QW = (QUAL_CYCLES > 2) ? $clog2(QUAL_CYCLES) : 1;
  localparam int unsigned HW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [QW-1:0] LOW_LAST  = QW'(QUAL_CYCLES - 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

  seqState_t   state;
  logic [QW-1:0] lowCnt;
  logic [HW-1:0] holdCnt;
  logic          lowFull;
  logic          qualify;
  logic          holdDone;

  assign lowFull  = (lowCnt == LOW_LAST);
  assign qualify  = !rstSync && lowFull;
  assign holdDone = (holdCnt == HOLD_LAST);

  // Consecutive-low counter, saturating one short of the window
  always_ff @(posedge clk or negedge powerOnRstN) begin
    if (!powerOnRstN) begin
      lowCnt <= '0;
    end else if (rstSync) begin
      lowCnt <= '0;
    end else if (!lowFull) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  // Phase sequencing; a qualified low wins over everything
  always_ff @(posedge clk or negedge powerOnRstN) begin
    if (!powerOnRstN) begin
      state   <= SEQ_ARMED;
      holdCnt <= '0;
    end else if (qualify) begin
      state   <= SEQ_ARMED;
      holdCnt <= '0;
    end else begin
      case (state)
        SEQ_ARMED: begin
          if (rstSync) begin
            state   <= SEQ_HOLD;
            holdCnt <= '0;
          end
        end
        SEQ_HOLD: begin
          if (holdDone) begin
            state <= SEQ_RUN;
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign sysRstN        = (state == SEQ_RUN);
  assign strobe.capture = (state != SEQ_RUN);
  assign strobe.update  = (state == SEQ_RUN);

endmodule

// File: rtl/strap_cfg_path.sv
module strap_cfg_path
  import strap_reset_pkg::*;
#(
  parameter int unsigned    ADDR_W    = 8,
  parameter int unsigned    DATA_W    = 8,
  parameter logic [ADDR_W-1:0] FAST_ADDR = 8'h0B,
  parameter int unsigned    FAST_BIT  = 4,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h09,
  parameter int unsigned    MODE_BIT  = 2
) (
  input  logic              clk,
  input  logic              powerOnRstN,
  input  seqStrobe_t        strobe,
  input  logic              fastSync,
  input  logic              sonetSync,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              fastSelEn,
  output logic              sonetMode,
  output logic              pairSelA
);

  function automatic logic pickBit(input logic [DATA_W-1:0] d, input int unsigned idx);
    logic v;
    v = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i == idx) v = d[i];
    end
    return v;
  endfunction

  logic wrFast;
  logic wrMode;

  assign wrFast = wrEn && (wrAddr == FAST_ADDR);
  assign wrMode = wrEn && (wrAddr == MODE_ADDR);

  always_ff @(posedge clk or negedge powerOnRstN) begin
    if (!powerOnRstN) begin
      fastSelEn <= 1'b0;
      sonetMode <= 1'b0;
      pairSelA  <= 1'b0;
    end else if (strobe.capture) begin
      fastSelEn <= fastSync;
      sonetMode <= sonetSync;
    end else if (strobe.update) begin
      if (fastSelEn) pairSelA <= fastSync;
      if (wrFast) fastSelEn <= pickBit(wrData, FAST_BIT);
      if (wrMode) sonetMode <= pickBit(wrData, MODE_BIT);
    end
  end

endmodule

// File: rtl/strap_reset_seq.sv
module strap_reset_seq
  import strap_reset_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = 640,
  parameter int unsigned HOLD_CYCLES = 6400000,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              powerOnRstN,
  input  logic              rstPinN,
  input  logic              fastSelPin,
  input  logic              sonetSdhPin,
  input  logic              masterPin,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              sysRstN,
  output logic              fastSelEn,
  output logic              sonetMode,
  output logic              masterLive,
  output logic              pairSelA
);

  localparam int unsigned PIN_CNT = 4;

  logic [PIN_CNT-1:0] pinSync;
  logic               rstSync;
  logic               fastSync;
  logic               sonetSync;
  seqStrobe_t         strobe;

  strap_sync #(
    .WIDTH (PIN_CNT),
    .STAGES(2)
  ) u_sync (
    .clk    (clk),
    .rstN   (powerOnRstN),
    .asyncIn({masterPin, sonetSdhPin, fastSelPin, rstPinN}),
    .syncOut(pinSync)
  );

  assign rstSync    = pinSync[0];
  assign fastSync   = pinSync[1];
  assign sonetSync  = pinSync[2];
  assign masterLive = pinSync[3];

  strap_reset_ctrl #(
    .QUAL_CYCLES(QUAL_CYCLES),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .powerOnRstN(powerOnRstN),
    .rstSync    (rstSync),
    .strobe     (strobe),
    .sysRstN    (sysRstN)
  );

  strap_cfg_path #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_path (
    .clk        (clk),
    .powerOnRstN(powerOnRstN),
    .strobe     (strobe),
    .fastSync   (fastSync),
    .sonetSync  (sonetSync),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .fastSelEn  (fastSelEn),
    .sonetMode  (sonetMode),
    .pairSelA   (pairSelA)
  );

endmodule

// File: rtl/strap_reset_chk.sv
module strap_reset_chk #(
  parameter int unsigned QUAL_CYCLES = 640,
  parameter int unsigned HOLD_CYCLES = 6400000
) (
  input logic clk,
  input logic powerOnRstN,
  input logic rstSync,
  input logic fastSync,
  input logic wrEn,
  input logic sysRstN,
  input logic fastSelEn,
  input logic sonetMode,
  input logic pairSelA
);

  localparam int unsigned LW = $clog2(QUAL_CYCLES + 1) + 1;
  localparam int unsigned RW = $clog2(HOLD_CYCLES + 1) + 1;
  localparam logic [LW-1:0] LOW_SAT = LW'(QUAL_CYCLES);
  localparam logic [RW-1:0] RST_SAT = RW'(HOLD_CYCLES);

  logic [LW-1:0] lowRun;
  logic [RW-1:0] rstRun;

  always_ff @(posedge clk or negedge powerOnRstN) begin
    if (!powerOnRstN) begin
      lowRun <= '0;
      rstRun <= '0;
    end else begin
      lowRun <= rstSync ? '0 : ((lowRun >= LOW_SAT) ? lowRun : lowRun + 1'b1);
      rstRun <= sysRstN ? '0 : ((rstRun >= RST_SAT) ? rstRun : rstRun + 1'b1);
    end
  end

  // R3: internal reset only enters after a full window of low samples
  a_r3_entry_needs_window: assert property (@(posedge clk) disable iff (!powerOnRstN)
    $fell(sysRstN) |-> (lowRun >= LOW_SAT));

  // R5: a full low window always leaves the block in reset
  a_r5_window_forces_reset: assert property (@(posedge clk) disable iff (!powerOnRstN)
    (lowRun >= LOW_SAT) |-> !sysRstN);

  // R4: release only after at least the hold time in reset
  a_r4_hold_length: assert property (@(posedge clk) disable iff (!powerOnRstN)
    $rose(sysRstN) |-> (rstRun >= RST_SAT));

  // R6: captured bits stay put while running unless written
  a_r6_straps_stable: assert property (@(posedge clk) disable iff (!powerOnRstN)
    (sysRstN && $past(sysRstN) && !$past(wrEn)) |-> ($stable(fastSelEn) && $stable(sonetMode)));

  // R7: pair choice frozen when disabled or in reset
  a_r7_pair_frozen: assert property (@(posedge clk) disable iff (!powerOnRstN)
    (!$past(sysRstN) || !$past(fastSelEn)) |-> $stable(pairSelA));

  // R7: pair choice follows the synchronized pin when enabled
  a_r7_pair_follows: assert property (@(posedge clk) disable iff (!powerOnRstN)
    ($past(sysRstN) && $past(fastSelEn)) |-> (pairSelA == $past(fastSync)));

endmodule

bind strap_reset_seq strap_reset_chk #(
  .QUAL_CYCLES(QUAL_CYCLES),
  .HOLD_CYCLES(HOLD_CYCLES)
) u_chk (
  .clk        (clk),
  .powerOnRstN(powerOnRstN),
  .rstSync    (rstSync),
  .fastSync   (fastSync),
  .wrEn       (wrEn),
  .sysRstN    (sysRstN),
  .fastSelEn  (fastSelEn),
  .sonetMode  (sonetMode),
  .pairSelA   (pairSelA)
);

// File: tb/strap_reset_seq_tb.sv
`timescale 1ns/1ps
module strap_reset_seq_tb;

  localparam int QUAL = 8;
  localparam int HOLD = 40;
  localparam int WATCHDOG = 20000;

  logic       clk = 1'b0;
  logic       powerOnRstN = 1'b0;
  logic       rstPinN = 1'b1;
  logic       fastSelPin = 1'b1;
  logic       sonetSdhPin = 1'b1;
  logic       masterPin = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       sysRstN, fastSelEn, sonetMode, masterLive, pairSelA;

  always #5 clk = ~clk;

  strap_reset_seq #(
    .QUAL_CYCLES(QUAL),
    .HOLD_CYCLES(HOLD)
  ) u_dut (
    .clk(clk), .powerOnRstN(powerOnRstN), .rstPinN(rstPinN),
    .fastSelPin(fastSelPin), .sonetSdhPin(sonetSdhPin), .masterPin(masterPin),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sysRstN(sysRstN), .fastSelEn(fastSelEn), .sonetMode(sonetMode),
    .masterLive(masterLive), .pairSelA(pairSelA)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int  mLowRun, mHoldCnt, mPhase;   // phase: 0 armed, 1 hold, 2 run
  bit  r1, r2, f1, f2, s1, s2, m1, m2;
  bit  eFast, eSon, ePair;

  always @(posedge clk or negedge powerOnRstN) begin
    if (!powerOnRstN) begin
      mLowRun = 0; mHoldCnt = 0; mPhase = 0;
      r1 = 0; r2 = 0; f1 = 0; f2 = 0; s1 = 0; s2 = 0; m1 = 0; m2 = 0;
      eFast = 0; eSon = 0; ePair = 0;
    end else begin
      bit rs, fs, ss, inRst, qual;
      rs = r2; fs = f2; ss = s2;
      inRst = (mPhase != 2);
      if (inRst) begin
        eFast = fs; eSon = ss;
      end else begin
        if (eFast) ePair = fs;
        if (wrEn && wrAddr == 8'h0B) eFast = wrData[4];
        if (wrEn && wrAddr == 8'h09) eSon = wrData[2];
      end
      if (!rs) begin
        if (mLowRun < QUAL) mLowRun++;
      end else begin
        mLowRun = 0;
      end
      qual = (mLowRun >= QUAL);
      if (qual) begin
        mPhase = 0; mHoldCnt = 0;
      end else if (mPhase == 0) begin
        if (rs) begin mPhase = 1; mHoldCnt = 0; end
      end else if (mPhase == 1) begin
        if (mHoldCnt == HOLD - 1) mPhase = 2;
        else mHoldCnt++;
      end
      r2 = r1; r1 = rstPinN;
      f2 = f1; f1 = fastSelPin;
      s2 = s1; s1 = sonetSdhPin;
      m2 = m1; m1 = masterPin;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (powerOnRstN && !done) begin
      check(sysRstN == (mPhase == 2), "R3 R4 R5 sysRstN", sysRstN, mPhase == 2);
      check(fastSelEn == eFast, "R6 R8 fastSelEn", fastSelEn, eFast);
      check(sonetMode == eSon, "R6 R8 sonetMode", sonetMode, eSon);
      check(pairSelA == ePair, "R7 pairSelA", pairSelA, ePair);
      check(masterLive == m2, "R2 R9 masterLive", masterLive, m2);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    cyc(1);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic lowPulse(input int n);
    rstPinN = 1'b0;
    cyc(n);
    rstPinN = 1'b1;
  endtask

  initial begin
    cyc(3);
    powerOnRstN = 1'b1;
    #1;
    // R1: power-on state
    check(sysRstN == 0, "R1 sysRstN", sysRstN, 0);
    check(fastSelEn == 0, "R1 fastSelEn", fastSelEn, 0);
    check(sonetMode == 0, "R1 sonetMode", sonetMode, 0);
    check(pairSelA == 0, "R1 pairSelA", pairSelA, 0);
    check(masterLive == 0, "R1 masterLive", masterLive, 0);

    // R9: master level live during reset
    cyc(1);
    masterPin = 1'b1;
    cyc(3);
    check(masterLive == 1 && sysRstN == 0, "R9 live in reset", masterLive, 1);

    // R4: release after the hold
    cyc(HOLD + 5);
    check(sysRstN == 1, "R4 released", sysRstN, 1);
    check(fastSelEn == 1, "R6 fast strap", fastSelEn, 1);
    check(sonetMode == 1, "R6 sonet strap", sonetMode, 1);

    // R7: live pair selection; R6: line pin ignored
    fastSelPin = 1'b0; sonetSdhPin = 1'b0;
    cyc(4);
    check(pairSelA == 0, "R7 pair B", pairSelA, 0);
    check(sonetMode == 1, "R6 pin ignored", sonetMode, 1);
    fastSelPin = 1'b1;
    cyc(4);
    check(pairSelA == 1, "R7 pair A", pairSelA, 1);

    // R8: writes, including an unrelated address
    regWrite(8'h10, 8'h00);
    check(fastSelEn == 1 && sonetMode == 1, "R8 other addr", fastSelEn, 1);
    regWrite(8'h0B, 8'hEF);
    check(fastSelEn == 0, "R8 fast write", fastSelEn, 0);
    regWrite(8'h09, 8'h04);
    check(sonetMode == 1, "R8 mode write", sonetMode, 1);
    regWrite(8'h09, 8'hFB);
    check(sonetMode == 0, "R8 mode clear", sonetMode, 0);
    fastSelPin = 1'b0;
    cyc(5);
    check(pairSelA == 1, "R7 frozen when disabled", pairSelA, 1);

    // R3: one sample short of the window
    lowPulse(QUAL - 1);
    cyc(6);
    check(sysRstN == 1, "R3 short pulse ignored", sysRstN, 1);

    // R3: exactly the window, straps changed during reset
    fastSelPin = 1'b1; sonetSdhPin = 1'b1;
    rstPinN = 1'b0;
    cyc(QUAL + 3);
    check(sysRstN == 0, "R3 qualified", sysRstN, 0);
    regWrite(8'h0B, 8'h00);
    check(fastSelEn == 1, "R8 write in reset ignored", fastSelEn, 1);
    rstPinN = 1'b1;
    cyc(10);
    // R4: short pulse inside the hold does not extend it
    lowPulse(QUAL - 2);
    fastSelPin = 1'b0; sonetSdhPin = 1'b0;
    cyc(HOLD);
    check(sysRstN == 1, "R4 hold not extended", sysRstN, 1);
    check(fastSelEn == 0 && sonetMode == 0, "R6 last-cycle capture", fastSelEn, 0);

    // R5: qualified low during the hold restarts it
    regWrite(8'h0B, 8'h10);
    lowPulse(QUAL + 2);
    cyc(HOLD - 10);
    lowPulse(QUAL + 1);
    cyc(HOLD - 5);
    check(sysRstN == 0, "R5 hold restarted", sysRstN, 0);
    cyc(20);
    check(sysRstN == 1, "R5 released after restart", sysRstN, 1);
    fastSelPin = 1'b1;
    cyc(4);
    check(pairSelA == 0, "R7 disabled by strap", pairSelA, 0);

    // R2: two-edge synchronizer latency
    masterPin = 1'b0;
    cyc(1);
    check(masterLive == 1, "R2 one edge", masterLive, 1);
    cyc(1);
    check(masterLive == 0, "R2 two edges", masterLive, 0);

    cyc(5);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule